// File: doc/BRIEF.md
# Interleaved Block Refill Engine

This block fetches one cache block of four words from a main memory that sits behind a slow, word-wide clocked bus. The memory is split into four banks, each one word wide, so word i of any block always lives in bank i. A requester raises a strobe with a word address while the engine is idle. The engine spends one cycle sending the address. All four banks then run their 15-cycle access at the same time. The four fetched words are then returned one per cycle on a single word-wide data bus, each marked with a valid flag. A done pulse closes the refill.

The point of the block is the overlap. The cost of a refill is one address cycle, plus a single access time, plus one cycle per word: 20 cycles, not four full accesses in a row. The engine measures that cost itself and presents the count of the last finished refill on an output.

The banks are modelled as internal arrays with a fixed access latency. After reset, the word at word address A holds SEED ^ A, with A zero-extended to the data width and SEED a parameter (default 32'hC3A5_0F00).

Top module: `refill_engine`

## Requirements
- R1: After reset, busy, rd_valid and rd_done are low and miss_cycles reads 0.
- R2: A request is taken only on a clock edge where req is high and the engine is idle. busy is then high for exactly 20 consecutive cycles, counting the address cycle as cycle 1, and falls after that.
- R3: rd_valid is high in cycles 17, 18, 19 and 20 of a refill, and low in every other cycle.
- R4: Words return in order 0, 1, 2, 3. Beat i carries the memory word at word address {block, i}, where block is blk_addr[ADDR_W-1:2], and that word equals SEED ^ address.
- R5: The two low bits of blk_addr do not affect which words are returned or the order they come in.
- R6: rd_done is high for exactly one cycle, the cycle of the fourth valid beat.
- R7: miss_cycles holds its earlier value while a refill is in progress. From the cycle after rd_done it shows the number of busy cycles of that refill, which is 20 with the default latency of 15.
- R8: While busy, req and blk_addr are ignored. This includes a request raised during the last beat: the ongoing refill's timing and data are unchanged, and no new refill follows it.
- R9: A request raised in the first idle cycle after rd_done is taken at once, so refills can run back to back with a single idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset; also fills the bank arrays |
| req | input | 1 | Refill request strobe |
| blk_addr | input | ADDR_W | Word address of the block; the low two bits are ignored |
| rd_valid | output | 1 | Data beat valid |
| rd_data | output | DATA_W | Returned word |
| rd_done | output | 1 | One-cycle pulse on the final beat |
| busy | output | 1 | High from the address cycle through the last beat |
| miss_cycles | output | PEN_W | Measured length in cycles of the last completed refill |

## Verification
Two events can land in the same cycle: the final data beat carrying rd_done, and a fresh request from the requester. The bench provokes this by holding req high, with a different address, through every busy cycle up to and including the final beat. It then expects the beat timing and data to be unchanged and busy to be low in the following cycle. A second scenario raises req in the very first idle cycle after rd_done. It expects a new 20-cycle refill to start from that edge, with the correct words from the new block.

// File: rtl/refill_pkg.sv
package refill_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WAIT = 2'd2,
        ST_XFER = 2'd3
    } rf_state_e;
endpackage

// File: rtl/refill_bank.sv
module refill_bank #(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter int LAT     = 15,
    parameter int BANK_ID = 0,
    parameter logic [DATA_W-1:0] SEED = 32'hC3A5_0F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-3:0] row,
    output logic              fin,
    output logic [DATA_W-1:0] data
);
    localparam int ROW_W = ADDR_W - 2;
    localparam int ROWS  = 1 << ROW_W;
    localparam int CNT_W = $clog2(LAT + 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [ROW_W-1:0]  row;
        logic [DATA_W-1:0] data;
    } bank_s;

    bank_s q, d;
    logic [DATA_W-1:0] mem_q [ROWS];

    // storage array, loaded with its fixed pattern during reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem_q[r] <= SEED ^ DATA_W'({ROW_W'(r), 2'(BANK_ID)});
            end
        end
    end

    always_comb begin
        d = q;
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.row  = row;
        end else if (q.busy) begin
            if (q.cnt == CNT_W'(LAT - 1)) begin
                d.busy = 1'b0;
                d.data = mem_q[q.row];
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fin  = q.busy && (q.cnt == CNT_W'(LAT - 1));
    assign data = q.data;

    // R3: an access completes once and the bank goes quiet
    a_r3_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);
    // R8: the controller never restarts a bank mid-access
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> !start);
endmodule

// File: rtl/refill_seq.sv
module refill_seq
    import refill_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LAT    = 15,
    parameter int WORDS  = 4,
    parameter int PEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              fin_all,
    output logic              start,
    output logic [ADDR_W-3:0] row,
    output logic [1:0]        beat,
    output logic              valid,
    output logic              done,
    output logic              busy,
    output logic [PEN_W-1:0]  pen
);
    localparam int PENALTY = 1 + LAT + WORDS;

    typedef struct packed {
        rf_state_e         st;
        logic [ADDR_W-3:0] row;
        logic [1:0]        beat;
        logic [PEN_W-1:0]  cnt;
        logic [PEN_W-1:0]  pen;
    } seq_s;

    seq_s q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: if (req) begin
                d.st  = ST_ADDR;
                d.row = addr[ADDR_W-1:2];
                d.cnt = PEN_W'(1);
            end
            ST_ADDR: begin
                d.st  = ST_WAIT;
                d.cnt = q.cnt + PEN_W'(1);
            end
            ST_WAIT: begin
                d.cnt = q.cnt + PEN_W'(1);
                if (fin_all) begin
                    d.st   = ST_XFER;
                    d.beat = '0;
                end
            end
            ST_XFER: begin
                if (q.beat == 2'(WORDS - 1)) begin
                    d.st  = ST_IDLE;
                    d.pen = q.cnt;
                end else begin
                    d.beat = q.beat + 2'd1;
                    d.cnt  = q.cnt + PEN_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign start = (q.st == ST_ADDR);
    assign row   = q.row;
    assign beat  = q.beat;
    assign valid = (q.st == ST_XFER);
    assign done  = valid && (q.beat == 2'(WORDS - 1));
    assign busy  = (q.st != ST_IDLE);
    assign pen   = q.pen;

    // R6: the closing pulse only rides on a data beat and ends the refill
    a_r6_done_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> valid);
    a_r6_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    // R7: measured penalty equals address + one access + the transfers
    a_r7_penalty: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (pen == PEN_W'(PENALTY)));
    // R8: latched block cannot move while a refill is running
    a_r8_row_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(row));
    // R3: beats begin only after every bank has finished its access
    a_r3_beats_after_banks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(fin_all));
endmodule

// File: rtl/refill_engine.sv
module refill_engine #(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter int ACC_LAT = 15,
    parameter int PEN_W   = $clog2(ACC_LAT + 6),
    parameter logic [DATA_W-1:0] SEED = 32'hC3A5_0F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] blk_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done,
    output logic              busy,
    output logic [PEN_W-1:0]  miss_cycles
);
    localparam int WORDS = 4;

    logic              start;
    logic [ADDR_W-3:0] row;
    logic [1:0]        beat;
    logic [WORDS-1:0]  fin;
    logic [DATA_W-1:0] bank_data [WORDS];

    refill_seq #(
        .ADDR_W(ADDR_W), .LAT(ACC_LAT), .WORDS(WORDS), .PEN_W(PEN_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(blk_addr),
        .fin_all(&fin), .start(start), .row(row), .beat(beat),
        .valid(rd_valid), .done(rd_done), .busy(busy), .pen(miss_cycles)
    );

    for (genvar b = 0; b < WORDS; b++) begin : g_bank
        refill_bank #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(ACC_LAT),
            .BANK_ID(b), .SEED(SEED)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .start(start), .row(row),
            .fin(fin[b]), .data(bank_data[b])
        );
    end

    assign rd_data = bank_data[beat];

    // R2: the bus is never valid outside a busy period
    a_r2_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);
endmodule

// File: tb/sim_refill_engine.sv
`timescale 1ns/1ps
module sim_refill_engine;
    localparam int AW = 10;
    localparam logic [31:0] SEED = 32'hC3A5_0F00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [AW-1:0] blk_addr = '0;
    logic        rd_valid, rd_done, busy;
    logic [31:0] rd_data;
    logic [4:0]  miss_cycles;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    refill_engine u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .blk_addr(blk_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done),
        .busy(busy), .miss_cycles(miss_cycles)
    );

    function automatic logic [31:0] exp_word(input logic [AW-1:0] a, input int i);
        return SEED ^ 32'({a[AW-1:2], 2'(i)});
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Starts at a falling edge; cycle 1 is the address cycle.
    task automatic refill(input logic [AW-1:0] a, input bit stray,
                          input string btag, input string dtag,
                          input logic [4:0] prev_pen);
        req = 1'b1;
        blk_addr = a;
        @(negedge clk);
        for (int k = 1; k <= 21; k++) begin
            if (k > 1) @(negedge clk);
            chk(btag, $sformatf("busy c%0d", k), 32'(busy), 32'(k <= 20));
            chk("R3", $sformatf("valid c%0d", k), 32'(rd_valid), 32'(k >= 17 && k <= 20));
            chk("R6", $sformatf("done c%0d", k), 32'(rd_done), 32'(k == 20));
            if (k >= 17 && k <= 20)
                chk(dtag, $sformatf("beat %0d", k - 17), rd_data, exp_word(a, k - 17));
            if (k == 10) chk("R7", "penalty held", 32'(miss_cycles), 32'(prev_pen));
            if (k == 21) chk("R7", "penalty", 32'(miss_cycles), 32'd20);
            if (stray && k <= 20) begin
                req = 1'b1;
                blk_addr = ~a;
            end else begin
                req = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "valid", 32'(rd_valid), 0);
        chk("R1", "done", 32'(rd_done), 0);
        chk("R1", "penalty", 32'(miss_cycles), 0);
    endtask

    task automatic t_single();
        refill(10'h040, 1'b0, "R2", "R4", 5'd0);
    endtask

    task automatic t_low_bits();
        // R5: misaligned address returns the aligned block
        refill(10'h043, 1'b0, "R2", "R5", 5'd20);
        refill(10'h2B1, 1'b0, "R2", "R5", 5'd20);
    endtask

    task automatic t_stray();
        // R8: requests held through every busy cycle, last beat included
        refill(10'h1F4, 1'b1, "R8", "R8", 5'd20);
        @(negedge clk);
        chk("R8", "no follow-on refill", 32'(busy), 0);
        chk("R8", "no follow-on beat", 32'(rd_valid), 0);
    endtask

    task automatic t_back_to_back();
        // R9: second request issued in the first idle cycle
        refill(10'h3FC, 1'b0, "R2", "R4", 5'd20);
        refill(10'h008, 1'b0, "R9", "R9", 5'd20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_low_bits();
        t_stray();
        t_back_to_back();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule